// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block holds the timing and counting logic of a dual-slope integrating analog-to-digital converter. After a start request it first holds the integrator discharge switch closed for a programmable number of clock cycles. It then routes the unknown input into the integrator for a fixed window of 2^N clock cycles. After one cycle with every switch open, it routes a reference of opposite polarity into the integrator. It counts clock cycles until the comparator reports that the integrator output has returned through zero.

The number of run-down cycles is the conversion result. The integrator time constant appears in both slopes and cancels, so no calibration constant is needed. A comparator that never trips within 2^N counts ends the conversion with an overrange flag. The analog integrator, the comparator and the reference sources sit outside the block. Only the switch selects, the discharge line, the comparator input and the digital result cross its boundary.

Top module: `dsc_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `sel_in`, `sel_ref`, `int_clr`, `busy`, `done` and `ovr` are 0 and `result` is 0.
- R2: A `start` sampled high at a clock edge while idle makes `int_clr` and `busy` high from the next cycle, for `clr_len` cycles (1 cycle when `clr_len` is 0).
- R3: Immediately after the discharge cycles, `sel_in` is high for exactly 2^RES_BITS consecutive cycles.
- R4: After run-up follows exactly one cycle with `busy` high and all of `sel_in`, `sel_ref`, `int_clr` low. At most one of the three switch lines is ever high.
- R5: In run-down, `sel_ref` is high and the run-down cycles are numbered 0, 1, 2 and so on. `cmp_in` (1 = integrator at or past zero) passes through a two-flop synchronizer. The first run-down cycle whose synchronized value is 1, numbered k < 2^RES_BITS, ends run-down. In the next cycle `done` is 1, `busy` is 0, `result` is k and `ovr` is 0.
- R6: If run-down reaches cycle number 2^RES_BITS, that cycle ends run-down whatever the comparator shows. `sel_ref` is then high for 2^RES_BITS+1 cycles, and in the next cycle `done` is 1, `ovr` is 1 and `result` is all ones.
- R7: `done` is high for exactly one cycle per conversion. `result` and `ovr` change only in a `done` cycle and hold their values until the next one, so a valid conversion clears a previous overrange.
- R8: `start` pulses while `busy` is high have no effect on the switch timing or on the result.
- R9: A `start` high in a `done` cycle is accepted, and discharge begins in the following cycle.
- R10: `cmp_in` has no effect outside run-down. A comparator that reads 1 during discharge and run-up does not end the conversion early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, sampled while idle |
| clr_len | input | CLR_W | Discharge length in cycles (0 means 1) |
| cmp_in | input | 1 | Asynchronous comparator, 1 when the integrator is at or past zero |
| sel_in | output | 1 | Connect input to integrator (run-up) |
| sel_ref | output | 1 | Connect reference to integrator (run-down) |
| int_clr | output | 1 | Integrator discharge switch |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | RES_BITS | Run-down count of the last conversion |
| ovr | output | 1 | Last conversion exceeded full scale |

## Verification
Two functions can fall in the same cycle: the closing of one conversion, with its `done` pulse and result capture, and the acceptance of the next `start`. The bench raises `start` in the `done` cycle of an overrange conversion. It checks that the old result and flag appear in that cycle, that discharge begins exactly one cycle later, and that the chained conversion clears `ovr`. A second coincidence is a comparator trip and the run-down count limit falling in the same cycle. A case whose trip lands exactly on count 2^RES_BITS must report overrange and not a wrapped result.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_RUNUP,
    ST_GAP,
    ST_RUNDN
  } dsc_state_e;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= 1'b0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= 1'b0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dsc_counter.sv
module dsc_counter #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dsc_fsm.sv
module dsc_fsm
  import dsc_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int CLR_W    = 8,
  parameter int CW       = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CLR_W-1:0]    clr_len,
  input  logic                cmp_s,
  input  logic [CW-1:0]       cnt,
  output logic                cnt_clr,
  output logic                sel_in,
  output logic                sel_ref,
  output logic                int_clr,
  output logic                busy,
  output logic                done,
  output logic [RES_BITS-1:0] result,
  output logic                ovr
);
  localparam logic [CW-1:0] RUN_LAST = CW'((1 << RES_BITS) - 1);
  localparam logic [CW-1:0] FULL     = CW'(1 << RES_BITS);

  dsc_state_e  state, nxt;
  logic        fin, ovr_hit;
  logic [CW-1:0] clr_last;

  assign clr_last = (clr_len == '0) ? '0 : (CW'(clr_len) - 1'b1);

  always_comb begin
    nxt     = state;
    cnt_clr = 1'b0;
    fin     = 1'b0;
    ovr_hit = 1'b0;
    case (state)
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (start) nxt = ST_CLEAR;
      end
      ST_CLEAR: begin
        if (cnt >= clr_last) begin
          nxt     = ST_RUNUP;
          cnt_clr = 1'b1;
        end
      end
      ST_RUNUP: begin
        if (cnt == RUN_LAST) begin
          nxt     = ST_GAP;
          cnt_clr = 1'b1;
        end
      end
      ST_GAP: begin
        nxt     = ST_RUNDN;
        cnt_clr = 1'b1;
      end
      ST_RUNDN: begin
        if (cnt == FULL) begin
          nxt     = ST_IDLE;
          fin     = 1'b1;
          ovr_hit = 1'b1;
          cnt_clr = 1'b1;
        end else if (cmp_s) begin
          nxt     = ST_IDLE;
          fin     = 1'b1;
          cnt_clr = 1'b1;
        end
      end
      default: begin
        nxt     = ST_IDLE;
        cnt_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sel_in  <= 1'b0;
      sel_ref <= 1'b0;
      int_clr <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
      ovr     <= 1'b0;
    end else begin
      state   <= nxt;
      sel_in  <= (nxt == ST_RUNUP);
      sel_ref <= (nxt == ST_RUNDN);
      int_clr <= (nxt == ST_CLEAR);
      busy    <= (nxt != ST_IDLE);
      done    <= fin;
      if (fin) begin
        ovr    <= ovr_hit;
        result <= ovr_hit ? '1 : cnt[RES_BITS-1:0];
      end
    end
  end
endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl #(
  parameter int RES_BITS    = 12,
  parameter int CLR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CLR_W-1:0]    clr_len,
  input  logic                cmp_in,
  output logic                sel_in,
  output logic                sel_ref,
  output logic                int_clr,
  output logic                busy,
  output logic                done,
  output logic [RES_BITS-1:0] result,
  output logic                ovr
);
  localparam int CW = (RES_BITS + 1 > CLR_W) ? RES_BITS + 1 : CLR_W;

  logic          cmp_s;
  logic          cnt_clr;
  logic [CW-1:0] cnt;

  dsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_in),
    .q   (cmp_s)
  );

  dsc_counter #(.W(CW)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .cnt (cnt)
  );

  dsc_fsm #(.RES_BITS(RES_BITS), .CLR_W(CLR_W), .CW(CW)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .clr_len (clr_len),
    .cmp_s   (cmp_s),
    .cnt     (cnt),
    .cnt_clr (cnt_clr),
    .sel_in  (sel_in),
    .sel_ref (sel_ref),
    .int_clr (int_clr),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .ovr     (ovr)
  );
endmodule

// File: rtl/dsc_ctrl_chk.sv
module dsc_ctrl_chk #(
  parameter int RES_BITS = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                sel_in,
  input logic                sel_ref,
  input logic                int_clr,
  input logic                busy,
  input logic                done,
  input logic [RES_BITS-1:0] result,
  input logic                ovr
);
  localparam int RW = RES_BITS + 2;
  localparam logic [RW-1:0] RUN_LEN = RW'(1 << RES_BITS);

  logic [RW-1:0] up_run;

  always_ff @(posedge clk) begin
    if (rst)         up_run <= '0;
    else if (sel_in) up_run <= up_run + 1'b1;
    else             up_run <= '0;
  end

  // R3
  runup_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_in) |-> (up_run == RUN_LEN));

  // R4
  switch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_in, sel_ref, int_clr}));

  // R4
  gap_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_ref) |-> (!$past(sel_in) && $past(sel_in, 2)));

  // R6
  ovr_full_chk: assert property (@(posedge clk) disable iff (rst)
    ovr |-> (&result));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(result) && $stable(ovr)));

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !sel_ref));
endmodule

bind dsc_ctrl dsc_ctrl_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sel_in  (sel_in),
  .sel_ref (sel_ref),
  .int_clr (int_clr),
  .busy    (busy),
  .done    (done),
  .result  (result),
  .ovr     (ovr)
);

// File: tb/dsc_ctrl_tb.sv
module dsc_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RES        = 8;
  localparam int CLRW       = 4;
  localparam int RUNLEN     = 1 << RES;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [CLRW-1:0] clr_len = '0;
  logic            cmp_in = 1'b0;
  logic            sel_in, sel_ref, int_clr, busy, done, ovr;
  logic [RES-1:0]  result;

  int errs = 0;
  int checks = 0;
  int vin = 0;
  int vref = 64;
  int acc = 0;
  int last_res = 0;
  int last_ovr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsc_ctrl #(.RES_BITS(RES), .CLR_W(CLRW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .start(start), .clr_len(clr_len), .cmp_in(cmp_in),
    .sel_in(sel_in), .sel_ref(sel_ref), .int_clr(int_clr), .busy(busy),
    .done(done), .result(result), .ovr(ovr)
  );

  // behavioural integrator and comparator, updated mid-cycle
  always @(negedge clk) begin
    if (int_clr)      acc = 0;
    else if (sel_in)  acc = acc + vin;
    else if (sel_ref) acc = acc - vref;
    cmp_in <= (acc <= 0);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int ctl();
    return {27'd0, sel_in, sel_ref, int_clr, busy, done};
  endfunction

  // one conversion; pre: start already raised in the previous done cycle
  task automatic run(input int vin_i, input int vref_i, input int len,
                     input bit pre, input bit inject, input bit chain, input string tag);
    int lc, r, dn, total, exp_res, e;
    bit eo;
    string ph;
    vin = vin_i;
    vref = vref_i;
    clr_len = CLRW'(len);
    lc = (len == 0) ? 1 : len;
    if (vin_i == 0) r = 0;
    else r = (RUNLEN * vin_i + vref_i - 1) / vref_i + 1;
    eo = (r >= RUNLEN);
    exp_res = eo ? RUNLEN - 1 : r;
    dn = eo ? RUNLEN + 1 : r + 1;
    total = lc + RUNLEN + 1 + dn;
    if (!pre) begin
      @(negedge clk);
      start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < total; k++) begin
      if (k < lc)                 begin e = 5'b00110; ph = "R2"; end
      else if (k < lc + RUNLEN)   begin e = 5'b10010; ph = "R3"; end
      else if (k == lc + RUNLEN)  begin e = 5'b00010; ph = "R4"; end
      else                        begin e = 5'b01010; ph = eo ? "R6" : "R5"; end
      chk(ph, {tag, " ctl"}, ctl(), e);
      // R8: extra start pulse while busy
      start = inject && (k == lc + 5 || k == lc + RUNLEN + 2);
      @(negedge clk);
    end
    start = 1'b0;
    ph = eo ? "R6" : "R5";
    chk(ph, {tag, " done ctl"}, ctl(), 5'b00001);
    chk(ph, {tag, " result"}, int'(result), exp_res);
    chk(ph, {tag, " ovr"}, int'(ovr), int'(eo));
    last_res = exp_res;
    last_ovr = int'(eo);
    if (chain) begin
      start = 1'b1; // R9: start coincides with done
    end else begin
      @(negedge clk);
      chk("R7", {tag, " done low"}, ctl(), 5'b00000);
      chk("R7", {tag, " result held"}, int'(result), last_res);
      chk("R7", {tag, " ovr held"}, int'(ovr), last_ovr);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ctl in reset", ctl(), 0);
    chk("R1", "result in reset", int'(result), 0);
    chk("R1", "ovr in reset", int'(ovr), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ctl after reset", ctl(), 0);
    chk("R1", "result after reset", int'(result), 0);
    run(10, 64, 3, 0, 0, 0, "mid");            // R5 result 41
    run(0, 64, 0, 0, 0, 0, "zero R10");        // comparator high early, result 0
    run(127, 128, 1, 0, 1, 0, "max R8");       // result 255, start while busy
    run(255, 256, 15, 0, 0, 1, "trip at limit"); // R6 overrange, chained
    run(5, 64, 2, 1, 0, 0, "chained R9");      // R7 ovr cleared, result 21
    run(100, 64, 4, 0, 0, 0, "over");          // R6
    run(1, 64, 5, 0, 0, 0, "small");           // R5 result 5
    repeat (4) begin
      @(negedge clk);
      chk("R7", "idle hold", int'(result), last_res);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule